// File: doc/BRIEF.md
# DS3 Receive Line-Code Decoder

This block sits between an external DS3 line interface unit and the receive framer. It takes the recovered line clock and either two rail inputs (dual-rail bipolar) or one NRZ input (single-rail unipolar). From these it produces one NRZ bit stream with a one-cycle strobe for each bit. In bipolar mode a configuration bit selects plain AMI decoding or B3ZS decoding. B3ZS decoding removes the zero-substitution codes. Bipolar violations that are not part of a valid substitution are reported on a one-cycle flag.

The whole block runs on one reference clock. The line clock and the rails are registered together. An edge detector on the registered line clock produces the sampling strobe, on the rising or the falling edge as configured. A watchdog counter measures the time since the last line clock transition and reports loss of clock, unless this is masked. An 8-bit control register holds the configuration. It passes the single/dual-rail choice, the transmit clock inversion and the transmit loss-of-clock mask to the transmit side. It also issues a one-cycle reframe request to the framer.

Top module: `ds3_rx_lcd`

## Requirements
- R1: After reset, `cfg_rdata` reads 8'hA0, and `tx_unipolar`, `tx_clk_inv`, `loc` and `reframe_req` are 0.
- R2: The control register bits are: bit 7 transmit loss-of-clock mask, bit 6 loss-of-clock status (read-only), bit 5 receive loss-of-clock mask, bit 4 line-code select (1 = AMI, 0 = B3ZS), bit 3 rail mode (1 = single-rail, 0 = dual-rail), bit 2 transmit clock invert, bit 1 receive clock invert, bit 0 reframe. A write takes effect on the next cycle. Bits 7, 3 and 2 drive `tx_loc_dis`, `tx_unipolar` and `tx_clk_inv`.
- R3: Writing 1 to bit 0 makes `reframe_req` high for exactly the one cycle after the write. Bit 0 always reads back 0.
- R4: With bit 1 = 0 the rails are sampled on a rising edge of `rx_lclk`. With bit 1 = 1 they are sampled on a falling edge. The rail values at the other edge have no effect.
- R5: In single-rail mode, `rx_pos` is the data, `rx_neg` is ignored and `lcv` stays 0.
- R6: In AMI mode, a pulse on either rail decodes to 1 and no pulse decodes to 0. A pulse with the same polarity as the previous pulse raises `lcv`. The first pulse seen since reset never does.
- R7: In B3ZS mode, a violation pulse whose preceding bit period had no pulse completes a substitution (0-0-V or B-0-V). That bit and the two before it decode to 0, and `lcv` stays low.
- R8: In B3ZS mode, a violation pulse whose preceding bit period had a pulse raises `lcv`, and the bit decodes to 1.
- R9: Every sampled bit appears on `dout` three active line clock edges later. `dout_stb` is high for one cycle per active edge.
- R10: With bit 5 = 0, if no `rx_lclk` transition of either polarity occurs for LOC_CYCLES reference cycles, `loc` and bit 6 become 1. They return to 0 after the next transition.
- R11: With bit 5 = 1, `loc` and bit 6 stay 0 however long the line clock is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Control register write enable |
| cfg_wdata | input | 8 | Control register write data |
| cfg_rdata | output | 8 | Control register read value |
| rx_lclk | input | 1 | Receive line clock from the line interface |
| rx_pos | input | 1 | Positive rail, or NRZ data in single-rail mode |
| rx_neg | input | 1 | Negative rail |
| dout | output | 1 | Decoded NRZ data |
| dout_stb | output | 1 | One-cycle strobe marking a new `dout` bit |
| lcv | output | 1 | Line code violation flag, aligned to `dout_stb` |
| reframe_req | output | 1 | One-cycle reframe request to the framer |
| loc | output | 1 | Receive loss-of-clock status |
| tx_unipolar | output | 1 | Rail mode passed to the transmit side |
| tx_clk_inv | output | 1 | Transmit clock edge select |
| tx_loc_dis | output | 1 | Transmit loss-of-clock mask |

## Verification
The hardest cases to reach are the B3ZS substitutions. They depend on the polarity of the last pulse, and that polarity carries over from earlier traffic, even from a different line-code mode. A B-0-V code whose B pulse is already in the look-behind window must also be cleared. The stimulus runs AMI and B3ZS segments back to back. The bench tracks the last pulse polarity across segments, so 0-0-V, B-0-V and a V right after a pulse all occur with known history. Edge selection is proven by driving the complement of each rail value at the inactive edge.

// File: rtl/ds3_lcd_pkg.sv
package ds3_lcd_pkg;

  typedef struct packed {
    logic tx_loc_dis;
    logic rx_loc_dis;
    logic ami_sel;
    logic unipolar;
    logic tx_inv;
    logic rx_inv;
  } lcd_cfg_t;

  localparam lcd_cfg_t CFG_RST = '{tx_loc_dis: 1'b1, rx_loc_dis: 1'b1,
                                   ami_sel: 1'b0, unipolar: 1'b0,
                                   tx_inv: 1'b0, rx_inv: 1'b0};

  localparam int B_TXLD = 7;
  localparam int B_LOC  = 6;
  localparam int B_RXLD = 5;
  localparam int B_AMI  = 4;
  localparam int B_UNI  = 3;
  localparam int B_TXI  = 2;
  localparam int B_RXI  = 1;
  localparam int B_RFR  = 0;

  localparam int LOOKBEHIND = 3;

endpackage

// File: rtl/lcd_cfg_regs.sv
module lcd_cfg_regs
  import ds3_lcd_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         we,
  input  logic [W-1:0] wdata,
  input  logic         loc_in,
  output lcd_cfg_t     cfg,
  output logic [W-1:0] rdata,
  output logic         reframe
);

  logic unused_ro_bit;
  assign unused_ro_bit = wdata[B_LOC];

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg     <= CFG_RST;
      reframe <= 1'b0;
    end else begin
      reframe <= we & wdata[B_RFR];
      if (we) begin
        cfg.tx_loc_dis <= wdata[B_TXLD];
        cfg.rx_loc_dis <= wdata[B_RXLD];
        cfg.ami_sel    <= wdata[B_AMI];
        cfg.unipolar   <= wdata[B_UNI];
        cfg.tx_inv     <= wdata[B_TXI];
        cfg.rx_inv     <= wdata[B_RXI];
      end
    end
  end

  always_comb begin
    rdata         = '0;
    rdata[B_TXLD] = cfg.tx_loc_dis;
    rdata[B_LOC]  = loc_in;
    rdata[B_RXLD] = cfg.rx_loc_dis;
    rdata[B_AMI]  = cfg.ami_sel;
    rdata[B_UNI]  = cfg.unipolar;
    rdata[B_TXI]  = cfg.tx_inv;
    rdata[B_RXI]  = cfg.rx_inv;
  end

endmodule

// File: rtl/lcd_line_sample.sv
module lcd_line_sample #(
  parameter int LOC_CYCLES = 32
) (
  input  logic clk,
  input  logic rst,
  input  logic lclk,
  input  logic pos,
  input  logic neg,
  input  logic rx_inv,
  input  logic rx_loc_dis,
  output logic stb,
  output logic pos_s,
  output logic neg_s,
  output logic loc
);

  localparam int CW = $clog2(LOC_CYCLES + 1);

  logic          lclk_r, lclk_d;
  logic [CW-1:0] idle_cnt;
  logic          any_edge;
  logic          idle_full;

  always_ff @(posedge clk) begin
    if (rst) begin
      lclk_r <= 1'b0;
      lclk_d <= 1'b0;
      pos_s  <= 1'b0;
      neg_s  <= 1'b0;
    end else begin
      lclk_r <= lclk;
      lclk_d <= lclk_r;
      pos_s  <= pos;
      neg_s  <= neg;
    end
  end

  assign stb       = rx_inv ? (lclk_d & ~lclk_r) : (lclk_r & ~lclk_d);
  assign any_edge  = lclk_r ^ lclk_d;
  assign idle_full = (idle_cnt == CW'(LOC_CYCLES));

  always_ff @(posedge clk) begin
    if (rst) begin
      idle_cnt <= '0;
      loc      <= 1'b0;
    end else begin
      if (any_edge)        idle_cnt <= '0;
      else if (!idle_full) idle_cnt <= idle_cnt + 1'b1;
      loc <= idle_full & ~any_edge & ~rx_loc_dis;
    end
  end

endmodule

// File: rtl/lcd_decoder.sv
module lcd_decoder
  import ds3_lcd_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic stb,
  input  logic pos,
  input  logic neg,
  input  logic unipolar,
  input  logic ami_sel,
  output logic dout,
  output logic dout_stb,
  output logic lcv
);

  logic [LOOKBEHIND-1:0] win;
  logic prev_pulse;
  logic pol_seen, pol_neg;
  logic pulse, is_neg, viol, subst;

  always_comb begin
    pulse  = unipolar ? pos : (pos | neg);
    is_neg = ~pos & neg;
    viol   = ~unipolar & pulse & pol_seen & (pol_neg == is_neg);
    subst  = viol & ~ami_sel & ~prev_pulse;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      win        <= '0;
      prev_pulse <= 1'b0;
      pol_seen   <= 1'b0;
      pol_neg    <= 1'b0;
      dout       <= 1'b0;
      dout_stb   <= 1'b0;
      lcv        <= 1'b0;
    end else begin
      dout_stb <= stb;
      lcv      <= 1'b0;
      if (stb) begin
        dout       <= win[LOOKBEHIND-1];
        prev_pulse <= pulse;
        lcv        <= viol & ~subst;
        if (subst) win <= '0;
        else       win <= {win[LOOKBEHIND-2:0], pulse};
        if (!unipolar && pulse) begin
          pol_seen <= 1'b1;
          pol_neg  <= is_neg;
        end
      end
    end
  end

endmodule

// File: rtl/ds3_rx_lcd.sv
module ds3_rx_lcd
  import ds3_lcd_pkg::*;
#(
  parameter int LOC_CYCLES = 32,
  parameter int CFG_W      = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic [CFG_W-1:0] cfg_wdata,
  output logic [CFG_W-1:0] cfg_rdata,
  input  logic             rx_lclk,
  input  logic             rx_pos,
  input  logic             rx_neg,
  output logic             dout,
  output logic             dout_stb,
  output logic             lcv,
  output logic             reframe_req,
  output logic             loc,
  output logic             tx_unipolar,
  output logic             tx_clk_inv,
  output logic             tx_loc_dis
);

  lcd_cfg_t cfg;
  logic     stb, pos_s, neg_s;

  lcd_cfg_regs #(.W(CFG_W)) u_regs (
    .clk(clk), .rst(rst), .we(cfg_we), .wdata(cfg_wdata), .loc_in(loc),
    .cfg(cfg), .rdata(cfg_rdata), .reframe(reframe_req)
  );

  lcd_line_sample #(.LOC_CYCLES(LOC_CYCLES)) u_samp (
    .clk(clk), .rst(rst), .lclk(rx_lclk), .pos(rx_pos), .neg(rx_neg),
    .rx_inv(cfg.rx_inv), .rx_loc_dis(cfg.rx_loc_dis),
    .stb(stb), .pos_s(pos_s), .neg_s(neg_s), .loc(loc)
  );

  lcd_decoder u_dec (
    .clk(clk), .rst(rst), .stb(stb), .pos(pos_s), .neg(neg_s),
    .unipolar(cfg.unipolar), .ami_sel(cfg.ami_sel),
    .dout(dout), .dout_stb(dout_stb), .lcv(lcv)
  );

  assign tx_unipolar = cfg.unipolar;
  assign tx_clk_inv  = cfg.tx_inv;
  assign tx_loc_dis  = cfg.tx_loc_dis;

endmodule

// File: rtl/ds3_rx_lcd_chk.sv
module ds3_rx_lcd_chk (
  input logic       clk,
  input logic       rst,
  input logic       cfg_we,
  input logic [7:0] cfg_wdata,
  input logic [7:0] cfg_rdata,
  input logic       dout_stb,
  input logic       lcv,
  input logic       reframe_req,
  input logic       loc,
  input logic       tx_unipolar
);

  p_reframe_from_write_r3: assert property (@(posedge clk) disable iff (rst)
    reframe_req |-> $past(cfg_we && cfg_wdata[0]));

  p_stb_single_r9: assert property (@(posedge clk) disable iff (rst)
    dout_stb |=> !dout_stb);

  p_unipolar_quiet_r5: assert property (@(posedge clk) disable iff (rst)
    (dout_stb && $past(tx_unipolar)) |-> !lcv);

  p_lcv_with_stb_r6: assert property (@(posedge clk) disable iff (rst)
    lcv |-> dout_stb);

  p_loc_masked_r11: assert property (@(posedge clk) disable iff (rst)
    $past(cfg_rdata[5]) |-> !loc);

endmodule

bind ds3_rx_lcd ds3_rx_lcd_chk chk_i (
  .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
  .cfg_rdata(cfg_rdata), .dout_stb(dout_stb), .lcv(lcv),
  .reframe_req(reframe_req), .loc(loc), .tx_unipolar(tx_unipolar)
);

// File: tb/ds3_rx_lcd_tb_top.sv
`timescale 1ns/1ps
module ds3_rx_lcd_tb_top;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cfg_we = 1'b0;
  logic [7:0] cfg_wdata = 8'h00;
  logic [7:0] cfg_rdata;
  logic       rx_lclk = 1'b0, rx_pos = 1'b0, rx_neg = 1'b0;
  logic       dout, dout_stb, lcv, reframe_req, loc;
  logic       tx_unipolar, tx_clk_inv, tx_loc_dis;

  int checks = 0;
  int errors = 0;
  bit exp_d[$];
  bit exp_f[$];
  int seg[$];
  string tag = "R9";
  int  pol_last = 0;
  bit  prev_raw = 1'b0;
  bit  inv = 1'b0;
  bit  done = 1'b0;

  always #5 clk = ~clk;

  ds3_rx_lcd #(.LOC_CYCLES(32)) dut_i (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .rx_lclk(rx_lclk), .rx_pos(rx_pos), .rx_neg(rx_neg),
    .dout(dout), .dout_stb(dout_stb), .lcv(lcv), .reframe_req(reframe_req),
    .loc(loc), .tx_unipolar(tx_unipolar), .tx_clk_inv(tx_clk_inv),
    .tx_loc_dis(tx_loc_dis)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic write_cfg(input logic [7:0] v);
    @(negedge clk);
    cfg_we = 1'b1; cfg_wdata = v;
    @(negedge clk);
    cfg_we = 1'b0; cfg_wdata = 8'h00;
  endtask

  task automatic drive_sym(input int kind, input int s);
    bit p, n;
    if (kind == 0) begin p = (s != 0); n = 1'b1; end
    else begin p = (s == 1); n = (s == 2); end
    @(negedge clk); rx_pos = p; rx_neg = n;
    repeat (2) @(negedge clk);
    rx_lclk = ~inv;
    repeat (2) @(negedge clk);
    rx_lclk = inv; rx_pos = ~p; rx_neg = ~n;
    repeat (2) @(negedge clk);
  endtask

  // kind: 0 single-rail, 1 AMI, 2 B3ZS; symbols 0 none, 1 positive, 2 negative
  task automatic run_seg(input int kind);
    bit dec[$];
    dec = {};
    foreach (seg[i]) begin
      int  s = seg[i];
      bit  p = (s != 0);
      bit  v = (kind != 0) && p && (pol_last != 0) && (s == pol_last);
      if (kind == 2 && v && !prev_raw) begin
        int n;
        dec.push_back(1'b0);
        n = dec.size();
        if (n >= 2) dec[n-2] = 1'b0;
        if (n >= 3) dec[n-3] = 1'b0;
        exp_f.push_back(1'b0);
      end else begin
        dec.push_back(p);
        exp_f.push_back(v);
      end
      prev_raw = p;
      if (kind != 0 && p) pol_last = s;
    end
    foreach (dec[i]) exp_d.push_back(dec[i]);
    foreach (seg[i]) drive_sym(kind, seg[i]);
  endtask

  always @(negedge clk) begin
    if (!rst && dout_stb) begin
      if (exp_d.size() == 0 || exp_f.size() == 0) begin
        check({tag, " unexpected dout_stb"}, 1, 0);
      end else begin
        bit ed, ef;
        ed = exp_d.pop_front();
        ef = exp_f.pop_front();
        check({tag, " dout"}, dout, ed);
        check({tag, " lcv"}, lcv, ef);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 cfg_rdata", cfg_rdata, 8'hA0);
    check("R1 tx_unipolar", tx_unipolar, 0);
    check("R1 tx_clk_inv", tx_clk_inv, 0);
    check("R1 reframe_req", reframe_req, 0);
    check("R1 loc", loc, 0);
    repeat (3) exp_d.push_back(1'b0);

    repeat (50) @(negedge clk);
    check("R11 loc while masked", loc, 0);
    check("R11 status bit", cfg_rdata[6], 0);

    write_cfg(8'hAC);
    check("R2 readback", cfg_rdata, 8'hAC);
    check("R2 tx_unipolar", tx_unipolar, 1);
    check("R2 tx_clk_inv", tx_clk_inv, 1);
    check("R2 tx_loc_dis", tx_loc_dis, 1);

    write_cfg(8'hA1);
    check("R3 reframe pulse", reframe_req, 1);
    @(negedge clk);
    check("R3 reframe single", reframe_req, 0);
    check("R3 bit0 reads 0", cfg_rdata[0], 0);

    write_cfg(8'hA8);
    tag = "R5/R9";
    seg = {1, 0, 1, 1, 0, 1, 0, 0, 0};
    run_seg(0);

    write_cfg(8'hB0);
    tag = "R6";
    seg = {1, 0, 2, 1, 1, 0, 2, 2, 0, 0, 0};
    run_seg(1);

    write_cfg(8'hA0);
    tag = "R7/R8";
    seg = {0, 0, 2, 1, 0, 1, 2, 1, 1, 0, 2, 0, 0, 0};
    run_seg(2);

    write_cfg(8'hB2);
    @(negedge clk);
    rx_lclk = 1'b1;
    inv = 1'b1;
    repeat (2) @(negedge clk);
    tag = "R4";
    seg = {1, 0, 2, 2, 0, 1, 0, 0, 0};
    run_seg(1);

    repeat (6) @(negedge clk);
    check("R9 all bits delivered", exp_d.size(), 3);

    write_cfg(8'h90);
    repeat (50) @(negedge clk);
    check("R10 loc set", loc, 1);
    check("R10 status bit", cfg_rdata[6], 1);
    rx_lclk = 1'b0;
    repeat (4) @(negedge clk);
    check("R10 loc cleared", loc, 0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule